// File: doc/BRIEF.md
# Fingerprint Frame Capture Controller

This block sits on the host side of a capacitive fingerprint sensor that scans its pixel array row by row. A controlling processor raises a start request. The controller then sends the sensor a one-clock, active-low start pulse and latches the 3-bit sensor gain code for the whole frame. It follows the sensor's row rhythm: a burst of data slots, then idle blanking clocks, repeated for every row. It writes only the converter samples that belong to data slots to a frame memory write port.

The sensor clock and the controller clock are the same, so each clock is one pixel slot. The 8-bit converter delivers the sample for a slot a fixed number of cycles (`CAP_LAT`) after that slot. `LEAD` clocks separate the start pulse cycle from the first data slot. Pixels are stored row-major at linear addresses. The default geometry is 128 rows of 192 pixels with 64 blanking clocks, which gives 24,576 writes per frame. A one-clock done pulse marks the end of a frame. Busy brackets the whole capture.

Top module: `fp_capture_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_we` are 0, `sensor_start_n` is 1 and `sensor_gain` is 0.
- R2: A start request sampled while idle drives `sensor_start_n` low for exactly the next cycle. `busy` goes high in that same cycle.
- R3: Let the pulse cycle be C0. Data slot c of row r lies in cycle C0 + LEAD + r*(COLS+GAP) + c. Its write appears in cycle slot + CAP_LAT + 1 and carries the `adc_data` value present in cycle slot + CAP_LAT. No write occurs during blanking clocks or while idle.
- R4: The address of the write for row r, column c (both from 0) is r*COLS + c, so consecutive writes in a row step the address by one.
- R5: Each frame produces exactly ROWS*COLS writes.
- R6: `done` is high for exactly one cycle, the cycle after the last write. `busy` is 0 from that cycle on.
- R7: A start request while `busy` is high produces no start pulse and leaves the gain and the write sequence unchanged.
- R8: `gain_in` is latched onto `sensor_gain` when a start is accepted, with bit 0 as the least significant bit. `sensor_gain` is held stable while busy, whatever `gain_in` does.
- R9: A start request in the cycle where `done` is high is accepted, and the next frame's start pulse follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Frame request from the processor |
| gain_in | input | GAIN_W | Gain code to use for the next frame |
| adc_data | input | DATA_W | Converter sample |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sensor_start_n | output | 1 | Active-low scan start pulse to the sensor |
| sensor_gain | output | GAIN_W | Latched gain code to the sensor |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | ADDR_W | Linear pixel address |
| mem_wdata | output | DATA_W | Pixel sample to store |

## Verification
The bench predicts the cycle of every write from the start pulse and the row rhythm. It drives a sample pattern that changes every cycle, so a controller that is off by one in its lead count, its converter latency or its blanking count stores the wrong sample or writes in a gap. It pokes start requests in the middle of a frame, where a design that rearmed would emit a second pulse, restart addresses or reload the gain. It toggles `gain_in` through each frame to expose a transparent gain path. It also chains a new request onto the done cycle: a design that cleared busy late would drop that request, and one that pulsed done twice or before the last write would be flagged.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_DATA = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_t;

  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int COLS   = 192,
  parameter int GAP    = 64,
  parameter int LEAD   = 1,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              slot_valid,
  output logic              slot_last,
  output logic [ADDR_W-1:0] slot_addr
);

  localparam int ROW_W  = safe_clog2(ROWS);
  localparam int COL_W  = safe_clog2(COLS);
  localparam int GAP_W  = safe_clog2(GAP);
  localparam int LEAD_W = safe_clog2(LEAD);

  seq_state_t        state_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [GAP_W-1:0]  gap_q;
  logic [LEAD_W-1:0] lead_q;
  logic [ADDR_W-1:0] addr_q;

  logic row_end, frame_end;
  assign row_end   = (col_q == COL_W'(COLS - 1));
  assign frame_end = (row_q == ROW_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      gap_q   <= '0;
      lead_q  <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (go) begin
            state_q <= SEQ_LEAD;
            lead_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            addr_q  <= '0;
          end
        end
        SEQ_LEAD: begin
          if (lead_q == LEAD_W'(LEAD - 1)) state_q <= SEQ_DATA;
          else lead_q <= lead_q + 1'b1;
        end
        SEQ_DATA: begin
          addr_q <= addr_q + 1'b1;
          if (row_end) begin
            col_q <= '0;
            if (frame_end) begin
              state_q <= SEQ_IDLE;
            end else begin
              state_q <= SEQ_GAP;
              gap_q   <= '0;
            end
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (gap_q == GAP_W'(GAP - 1)) begin
            state_q <= SEQ_DATA;
            row_q   <= row_q + 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign slot_valid = (state_q == SEQ_DATA);
  assign slot_last  = slot_valid && row_end && frame_end;
  assign slot_addr  = addr_q;

endmodule

// File: rtl/fpc_capture.sv
module fpc_capture #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int LAT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] sample,
  output logic              wr_en,
  output logic              wr_last,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              v_d, l_d;
  logic [ADDR_W-1:0] a_d;

  generate
    if (LAT == 0) begin : g_direct
      assign v_d = in_valid;
      assign l_d = in_last;
      assign a_d = in_addr;
    end else begin : g_pipe
      logic [LAT-1:0]    v_sr;
      logic [LAT-1:0]    l_sr;
      logic [ADDR_W-1:0] a_sr [LAT];

      always_ff @(posedge clk) begin
        if (rst) begin
          v_sr <= '0;
          l_sr <= '0;
        end else begin
          v_sr[0] <= in_valid;
          l_sr[0] <= in_last;
          for (int i = 1; i < LAT; i++) begin
            v_sr[i] <= v_sr[i-1];
            l_sr[i] <= l_sr[i-1];
          end
        end
      end

      always_ff @(posedge clk) begin
        a_sr[0] <= in_addr;
        for (int i = 1; i < LAT; i++) a_sr[i] <= a_sr[i-1];
      end

      assign v_d = v_sr[LAT-1];
      assign l_d = l_sr[LAT-1];
      assign a_d = a_sr[LAT-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_last <= 1'b0;
    end else begin
      wr_en   <= v_d;
      wr_last <= v_d && l_d;
    end
  end

  always_ff @(posedge clk) begin
    wr_addr <= a_d;
    wr_data <= sample;
  end

endmodule

// File: rtl/fpc_gain_latch.sv
module fpc_gain_latch #(
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [GAIN_W-1:0] gain_in,
  output logic [GAIN_W-1:0] gain_out
);

  always_ff @(posedge clk) begin
    if (rst)       gain_out <= '0;
    else if (load) gain_out <= gain_in;
  end

endmodule

// File: rtl/fp_capture_ctrl.sv
module fp_capture_ctrl
  import fpc_pkg::*;
#(
  parameter int  ROWS    = 128,
  parameter int  COLS    = 192,
  parameter int  GAP     = 64,
  parameter int  LEAD    = 1,
  parameter int  CAP_LAT = 1,
  parameter int  DATA_W  = 8,
  parameter int  GAIN_W  = 3,
  localparam int PIXELS  = ROWS * COLS,
  localparam int ADDR_W  = safe_clog2(PIXELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [GAIN_W-1:0] gain_in,
  input  logic [DATA_W-1:0] adc_data,
  output logic              busy,
  output logic              done,
  output logic              sensor_start_n,
  output logic [GAIN_W-1:0] sensor_gain,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic              accept;
  logic              busy_q, done_q, start_n_q;
  logic              slot_valid, slot_last;
  logic [ADDR_W-1:0] slot_addr;
  logic              wr_last;

  assign accept = start_req && !busy_q;

  fpc_seq #(
    .ROWS(ROWS), .COLS(COLS), .GAP(GAP), .LEAD(LEAD), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .go(accept),
    .slot_valid(slot_valid), .slot_last(slot_last), .slot_addr(slot_addr)
  );

  fpc_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(CAP_LAT)
  ) u_cap (
    .clk(clk), .rst(rst),
    .in_valid(slot_valid), .in_last(slot_last), .in_addr(slot_addr),
    .sample(adc_data),
    .wr_en(mem_we), .wr_last(wr_last), .wr_addr(mem_addr), .wr_data(mem_wdata)
  );

  fpc_gain_latch #(
    .GAIN_W(GAIN_W)
  ) u_gain (
    .clk(clk), .rst(rst), .load(accept), .gain_in(gain_in), .gain_out(sensor_gain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      start_n_q <= 1'b1;
    end else begin
      start_n_q <= !accept;
      done_q    <= mem_we && wr_last;
      if (accept)                busy_q <= 1'b1;
      else if (mem_we && wr_last) busy_q <= 1'b0;
    end
  end

  assign busy           = busy_q;
  assign done           = done_q;
  assign sensor_start_n = start_n_q;

endmodule

// File: rtl/fp_capture_ctrl_chk.sv
module fp_capture_ctrl_chk #(
  parameter int PIXELS = 24576,
  parameter int ADDR_W = 15,
  parameter int GAIN_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              sensor_start_n,
  input logic [GAIN_W-1:0] sensor_gain,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
    !sensor_start_n |=> sensor_start_n);

  a_r2_pulse_busy: assert property (@(posedge clk) disable iff (rst)
    !sensor_start_n |-> busy);

  a_r3_write_in_frame: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, mem_addr} < (ADDR_W + 1)'(PIXELS)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_we));

  a_r8_gain_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sensor_gain));

endmodule

bind fp_capture_ctrl fp_capture_ctrl_chk #(
  .PIXELS(PIXELS), .ADDR_W(ADDR_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .sensor_start_n(sensor_start_n), .sensor_gain(sensor_gain),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/fp_capture_ctrl_bench.sv
module fp_capture_ctrl_bench;

  localparam int ROWS = 3;
  localparam int COLS = 5;
  localparam int GAP  = 2;
  localparam int LEAD = 2;
  localparam int LAT  = 2;
  localparam int AW   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic [2:0] gain_in = 3'd0;
  logic [7:0] adc_data = 8'd0;
  logic       busy, done, sensor_start_n, mem_we;
  logic [2:0] sensor_gain;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0, errors = 0;
  int cyc = 0, c0 = 0, wcount = 0, last_we = 0, pulses = 0;
  logic [7:0] seed = 8'h00;

  always #2.5 clk = ~clk;

  fp_capture_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .GAP(GAP), .LEAD(LEAD), .CAP_LAT(LAT),
    .DATA_W(8), .GAIN_W(3)
  ) u_fp_capture_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .gain_in(gain_in),
    .adc_data(adc_data), .busy(busy), .done(done),
    .sensor_start_n(sensor_start_n), .sensor_gain(sensor_gain),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] pat(input int c);
    return 8'(c * 7) ^ seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) adc_data <= pat(cyc);

  // Write monitor: predicts slot timing, address and sample for each write
  always @(negedge clk) begin
    if (!rst) begin
      if (!sensor_start_n) begin
        c0 = cyc;
        wcount = 0;
        pulses++;
      end
      if (mem_we) begin
        int r, c, slot;
        r = wcount / COLS;
        c = wcount % COLS;
        slot = c0 + LEAD + r * (COLS + GAP) + c;
        chk(int'(mem_addr) == wcount, "R4 address", int'(mem_addr), wcount);
        chk(cyc == slot + LAT + 1, "R3 write cycle", cyc, slot + LAT + 1);
        chk(mem_wdata == pat(slot + LAT), "R3 sample", int'(mem_wdata), int'(pat(slot + LAT)));
        wcount++;
        last_we = cyc;
      end
      if (done) begin
        chk(wcount == ROWS * COLS, "R5 write count", wcount, ROWS * COLS);
        chk(cyc == last_we + 1, "R6 done timing", cyc, last_we + 1);
        chk(!busy, "R6 busy low with done", int'(busy), 0);
      end
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we, "R1 idle flags", int'({busy, done, mem_we}), 0);
    chk(sensor_start_n == 1'b1, "R1 start high", int'(sensor_start_n), 1);
    chk(sensor_gain == 3'd0, "R1 gain zero", int'(sensor_gain), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Caller is at a negedge; request is sampled at the next posedge
  task automatic t_begin(input logic [2:0] g, input logic [7:0] s, input string tag);
    seed = s;
    gain_in = g;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(sensor_start_n == 1'b0, tag, int'(sensor_start_n), 0);
    chk(busy == 1'b1, "R2 busy with pulse", int'(busy), 1);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    chk(sensor_gain == g, "R8 gain latched", int'(sensor_gain), int'(g));
    @(negedge clk);
    chk(sensor_start_n == 1'b1, "R2 pulse one cycle", int'(sensor_start_n), 1);
  endtask

  // Runs to the done cycle; returns at the negedge where done is high
  task automatic t_finish(input logic [2:0] g, input bit poke, input int p_before);
    bit moved = 0;
    int n = 0;
    gain_in = ~g;
    while (!done) begin
      if (poke && n == 4) begin start_req = 1'b1; gain_in = g ^ 3'b011; end
      if (poke && n == 6) start_req = 1'b0;
      if (busy && sensor_gain != g) moved = 1;
      n++;
      @(negedge clk);
    end
    start_req = 1'b0;
    chk(!moved, "R8 gain held", int'(moved), 0);
    chk(pulses == p_before + 1, poke ? "R7 no extra pulse" : "R2 one pulse", pulses, p_before + 1);
    if (poke) chk(sensor_gain == g, "R7 gain unchanged", int'(sensor_gain), int'(g));
  endtask

  task automatic t_frame_plain();
    int p;
    p = pulses;
    t_begin(3'b101, 8'h3C, "R2 pulse low");
    t_finish(3'b101, 0, p);
    @(negedge clk);
    chk(!done, "R6 done drops", int'(done), 0);
  endtask

  task automatic t_frame_poked();
    int p;
    p = pulses;
    t_begin(3'b010, 8'hA5, "R2 pulse low");
    t_finish(3'b010, 1, p);
    @(negedge clk);
  endtask

  task automatic t_idle_quiet();
    bit wrote = 0;
    repeat (12) begin
      if (mem_we || !sensor_start_n) wrote = 1;
      @(negedge clk);
    end
    chk(!wrote, "R3 no write while idle", int'(wrote), 0);
  endtask

  task automatic t_chained();
    int p;
    p = pulses;
    t_begin(3'b111, 8'h5A, "R2 pulse low");
    t_finish(3'b111, 0, p);
    p = pulses;
    t_begin(3'b001, 8'hC3, "R9 chained start");
    t_finish(3'b001, 0, p);
    @(negedge clk);
    chk(!busy, "R9 second frame ends", int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_frame_plain();
    t_idle_quiet();
    t_frame_poked();
    t_chained();
    t_idle_quiet();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule